// File: doc/BRIEF.md
# LIN Identifier and Checksum Unit

This block does the header and checksum arithmetic for a LIN controller. A header load presents a 6-bit frame identifier, a 4-bit length control and a checksum-mode select. The block registers the 8-bit protected identifier, which is the identifier with its two parity bits on top. It also registers the resolved payload length and opens a frame.

Payload bytes then arrive one per valid strobe. The byte that carries the end-of-frame marker closes the frame, and the inverted checksum is then published. The checksum is an 8-bit sum in which each carry out of bit 7 is added back in.

On receive, the serial front end presents the checksum byte it took off the bus on a separate strobe. The unit then raises a mismatch flag whenever that byte differs from the checksum it computed.

Top module: `lin_frame_arith`

## Requirements
- R1: One cycle after `hdr_load`, `pid[5:0]` equals the loaded identifier. `pid[6]` equals id0^id1^id2^id4 and `pid[7]` equals the inverse of id1^id3^id4^id5.
- R2: A length control value from 1 to 8 gives `pay_len` equal to that value, one cycle after `hdr_load`.
- R3: A length control value of 0, or any value from 9 to 14, gives `pay_len` = 8.
- R4: A length control value of 15 (all ones) takes the length from id[5:4]: 00 gives 2, 01 gives 2, 10 gives 4 and 11 gives 8.
- R5: With `enh_mode` = 0 (classic), `csum` is the inverse of the end-around-carry sum of the accepted data bytes only.
- R6: With `enh_mode` = 1 (enhanced), the sum also includes the protected identifier byte.
- R7: Each addition that carries out of bit 7 adds that carry back into bit 0, so 0xFF, 0xFF, 0x01 sum to 0x01 and give a checksum of 0xFE.
- R8: Once a frame holds `pay_len` bytes, any further bytes in it are not added. A byte that carries `byte_last` still closes the frame.
- R9: `csum_done` rises one cycle after the strobe that carries `byte_last`. After that, `csum` and `csum_done` hold until the next `hdr_load`.
- R10: An `rx_chk_valid` strobe while `csum_done` is high sets `chk_err` on the next cycle to (`rx_chk_byte` != `csum`). A strobe while `csum_done` is low is ignored. `hdr_load` clears `chk_err`.
- R11: After reset, `pid`, `pay_len`, `csum`, `csum_done` and `chk_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdr_load | input | 1 | Latch the header fields and open a new frame |
| frame_id | input | 6 | Frame identifier |
| len_ctrl | input | 4 | Length control (15 = decode from the identifier) |
| enh_mode | input | 1 | 1 selects the enhanced checksum, 0 the classic one |
| byte_valid | input | 1 | Payload byte strobe |
| byte_data | input | 8 | Payload byte |
| byte_last | input | 1 | Marks the final byte of the frame |
| rx_chk_valid | input | 1 | Strobe for the received checksum byte |
| rx_chk_byte | input | 8 | Checksum byte taken off the bus |
| pid | output | 8 | Protected identifier |
| pay_len | output | 4 | Resolved payload length |
| csum | output | 8 | Computed checksum |
| csum_done | output | 1 | The checksum is final |
| chk_err | output | 1 | The received checksum does not match |

## Verification
Every result sits one register away from the strobe that causes it:
- `pid` and `pay_len` are due one cycle after `hdr_load`.
- `csum` and `csum_done` are due one cycle after the strobe that carries `byte_last`.
- `chk_err` is due one cycle after `rx_chk_valid`.

The bench drives each strobe for one full period, starting at a falling edge. It reads the outputs at the following falling edge, which is exactly one rising edge after the stimulus. Checks of held values sample again after idle cycles.

// File: rtl/lin_arith_pkg.sv
package lin_arith_pkg;
    localparam int ID_W      = 6;
    localparam int LEN_W     = 4;
    localparam int BYTE_W    = 8;
    localparam int MAX_BYTES = 8;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);

    typedef struct packed {
        logic [BYTE_W-1:0] pid;
        logic [LEN_W-1:0]  len;
    } hdr_t;

    typedef struct packed {
        logic [BYTE_W-1:0] acc;
        logic [CNT_W-1:0]  cnt;
        logic              open;
        logic              done;
        logic [BYTE_W-1:0] csum;
        logic              err;
    } acc_state_t;
endpackage

// File: rtl/lin_pid_gen.sv
module lin_pid_gen
    import lin_arith_pkg::*;
(
    input  logic [ID_W-1:0]   id_i,
    output logic [BYTE_W-1:0] pid_o
);
    logic par_lo;
    logic par_hi;

    always_comb begin
        par_lo = id_i[0] ^ id_i[1] ^ id_i[2] ^ id_i[4];
        par_hi = ~(id_i[1] ^ id_i[3] ^ id_i[4] ^ id_i[5]);
        pid_o  = {par_hi, par_lo, id_i};
    end
endmodule

// File: rtl/lin_len_decode.sv
module lin_len_decode
    import lin_arith_pkg::*;
(
    input  logic [LEN_W-1:0] len_ctrl_i,
    input  logic [ID_W-1:0]  id_i,
    output logic [LEN_W-1:0] len_o
);
    localparam logic [LEN_W-1:0] AUTO_CODE = {LEN_W{1'b1}};
    localparam logic [LEN_W-1:0] MAX_LEN   = LEN_W'(MAX_BYTES);

    always_comb begin
        if (len_ctrl_i == AUTO_CODE) begin
            // length class carried in the two top identifier bits
            unique case (id_i[ID_W-1 -: 2])
                2'b00, 2'b01: len_o = LEN_W'(2);
                2'b10:        len_o = LEN_W'(4);
                default:      len_o = LEN_W'(8);
            endcase
        end else if (len_ctrl_i == '0 || len_ctrl_i > MAX_LEN) begin
            len_o = MAX_LEN;
        end else begin
            len_o = len_ctrl_i;
        end
    end
endmodule

// File: rtl/lin_csum_core.sv
module lin_csum_core
    import lin_arith_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              enh_i,
    input  logic [BYTE_W-1:0] pid_load_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              bvalid_i,
    input  logic [BYTE_W-1:0] bdata_i,
    input  logic              blast_i,
    input  logic              rx_valid_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    output logic [BYTE_W-1:0] csum_o,
    output logic              done_o,
    output logic              err_o
);
    acc_state_t st_d, st_q;
    logic              take_byte;
    logic [BYTE_W:0]   raw_sum;
    logic [BYTE_W-1:0] acc_new;

    always_comb begin
        st_d      = st_q;
        take_byte = st_q.open && bvalid_i && (int'(st_q.cnt) < int'(len_i));
        raw_sum   = {1'b0, st_q.acc} + {1'b0, bdata_i};
        // end-around carry: fold bit 8 back into bit 0
        acc_new   = take_byte ? (raw_sum[BYTE_W-1:0] + BYTE_W'(raw_sum[BYTE_W])) : st_q.acc;

        if (load_i) begin
            st_d.acc  = enh_i ? pid_load_i : '0;
            st_d.cnt  = '0;
            st_d.open = 1'b1;
            st_d.done = 1'b0;
            st_d.csum = '0;
            st_d.err  = 1'b0;
        end else begin
            if (st_q.open && bvalid_i) begin
                st_d.acc = acc_new;
                if (take_byte) st_d.cnt = st_q.cnt + CNT_W'(1);
                if (blast_i) begin
                    st_d.open = 1'b0;
                    st_d.done = 1'b1;
                    st_d.csum = ~acc_new;
                end
            end
            if (st_q.done && rx_valid_i) begin
                st_d.err = (rx_byte_i != st_q.csum);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign csum_o = st_q.csum;
    assign done_o = st_q.done;
    assign err_o  = st_q.err;

    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) <= int'(len_i));

    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !load_i |=> done_o && $stable(csum_o));

    a_r9_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.open && bvalid_i && blast_i && !load_i |=> done_o);

    a_r10_err_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);
endmodule

// File: rtl/lin_frame_arith.sv
module lin_frame_arith
    import lin_arith_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_load,
    input  logic [ID_W-1:0]   frame_id,
    input  logic [LEN_W-1:0]  len_ctrl,
    input  logic              enh_mode,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_last,
    input  logic              rx_chk_valid,
    input  logic [BYTE_W-1:0] rx_chk_byte,
    output logic [BYTE_W-1:0] pid,
    output logic [LEN_W-1:0]  pay_len,
    output logic [BYTE_W-1:0] csum,
    output logic              csum_done,
    output logic              chk_err
);
    hdr_t hdr_d, hdr_q;
    logic [BYTE_W-1:0] pid_w;
    logic [LEN_W-1:0]  len_w;

    lin_pid_gen u_pid (
        .id_i  (frame_id),
        .pid_o (pid_w)
    );

    lin_len_decode u_len (
        .len_ctrl_i (len_ctrl),
        .id_i       (frame_id),
        .len_o      (len_w)
    );

    always_comb begin
        hdr_d = hdr_q;
        if (hdr_load) begin
            hdr_d.pid = pid_w;
            hdr_d.len = len_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hdr_q <= '0;
        else        hdr_q <= hdr_d;
    end

    lin_csum_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (hdr_load),
        .enh_i      (enh_mode),
        .pid_load_i (pid_w),
        .len_i      (hdr_q.len),
        .bvalid_i   (byte_valid),
        .bdata_i    (byte_data),
        .blast_i    (byte_last),
        .rx_valid_i (rx_chk_valid),
        .rx_byte_i  (rx_chk_byte),
        .csum_o     (csum),
        .done_o     (csum_done),
        .err_o      (chk_err)
    );

    assign pid     = hdr_q.pid;
    assign pay_len = hdr_q.len;

    a_r1_pid_id: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_load |=> pid[ID_W-1:0] == $past(frame_id));

    a_r2_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_load |=> (pay_len != '0) && (int'(pay_len) <= MAX_BYTES));

    a_r1_pid_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_load |=> $stable(pid) && $stable(pay_len));
endmodule

// File: tb/test_lin_frame_arith.sv
module test_lin_frame_arith;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hdr_load = 1'b0;
    logic [5:0] frame_id = '0;
    logic [3:0] len_ctrl = '0;
    logic       enh_mode = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       byte_last = 1'b0;
    logic       rx_chk_valid = 1'b0;
    logic [7:0] rx_chk_byte = '0;
    logic [7:0] pid;
    logic [3:0] pay_len;
    logic [7:0] csum;
    logic       csum_done;
    logic       chk_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lin_frame_arith i_lin_frame_arith (
        .clk(clk), .rst_n(rst_n), .hdr_load(hdr_load), .frame_id(frame_id),
        .len_ctrl(len_ctrl), .enh_mode(enh_mode), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_last(byte_last), .rx_chk_valid(rx_chk_valid),
        .rx_chk_byte(rx_chk_byte), .pid(pid), .pay_len(pay_len), .csum(csum),
        .csum_done(csum_done), .chk_err(chk_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_pid(input logic [5:0] id);
        logic p0, p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = !(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return {p1, p0, id};
    endfunction

    function automatic int m_len(input int lc, input logic [5:0] id);
        if (lc == 15) return (id[5:4] == 2'b11) ? 8 : (id[5:4] == 2'b10) ? 4 : 2;
        if (lc == 0 || lc > 8) return 8;
        return lc;
    endfunction

    function automatic logic [7:0] m_csum(input logic [7:0] b [8], input int n,
                                          input logic enh, input logic [7:0] p);
        int s;
        s = enh ? int'(p) : 0;
        for (int i = 0; i < n; i++) begin
            s = s + int'(b[i]);
            if (s > 255) s = s - 255;
        end
        return ~8'(s);
    endfunction

    task automatic header(input logic [5:0] id, input logic [3:0] lc, input logic enh);
        @(negedge clk);
        hdr_load = 1'b1; frame_id = id; len_ctrl = lc; enh_mode = enh;
        @(negedge clk);
        hdr_load = 1'b0;
    endtask

    task automatic send(input logic [7:0] b [8], input int n);
        for (int i = 0; i < n; i++) begin
            byte_valid = 1'b1; byte_data = b[i]; byte_last = (i == n - 1);
            @(negedge clk);
        end
        byte_valid = 1'b0; byte_last = 1'b0;
    endtask

    task automatic rx_check(input logic [7:0] v);
        rx_chk_valid = 1'b1; rx_chk_byte = v;
        @(negedge clk);
        rx_chk_valid = 1'b0;
    endtask

    task automatic run_frame(input string req, input logic [5:0] id, input logic [3:0] lc,
                             input logic enh, input logic [7:0] b [8], input int n);
        int used;
        header(id, lc, enh);
        send(b, n);
        used = (n < m_len(lc, id)) ? n : m_len(lc, id);
        check({req, " done"}, int'(csum_done), 1);
        check({req, " csum"}, int'(csum), int'(m_csum(b, used, enh, m_pid(id))));
    endtask

    task automatic t_reset();
        check("R11 pid", int'(pid), 0);
        check("R11 pay_len", int'(pay_len), 0);
        check("R11 csum", int'(csum), 0);
        check("R11 done", int'(csum_done), 0);
        check("R11 err", int'(chk_err), 0);
    endtask

    task automatic t_pid();
        logic [5:0] ids [6] = '{6'h00, 6'h3C, 6'h15, 6'h3F, 6'h2A, 6'h01};
        foreach (ids[i]) begin
            header(ids[i], 4'd4, 1'b0);
            check("R1 pid", int'(pid), int'(m_pid(ids[i])));
        end
    endtask

    task automatic t_len();
        for (int lc = 1; lc <= 8; lc++) begin
            header(6'h05, 4'(lc), 1'b0);
            check("R2 direct length", int'(pay_len), lc);
        end
        header(6'h05, 4'd0, 1'b0);  check("R3 zero clamps", int'(pay_len), 8);
        header(6'h05, 4'd9, 1'b0);  check("R3 nine clamps", int'(pay_len), 8);
        header(6'h05, 4'd14, 1'b0); check("R3 fourteen clamps", int'(pay_len), 8);
        header(6'h05, 4'd15, 1'b0); check("R4 id 00", int'(pay_len), 2);
        header(6'h12, 4'd15, 1'b0); check("R4 id 01", int'(pay_len), 2);
        header(6'h25, 4'd15, 1'b0); check("R4 id 10", int'(pay_len), 4);
        header(6'h3A, 4'd15, 1'b0); check("R4 id 11", int'(pay_len), 8);
    endtask

    task automatic t_sums();
        logic [7:0] a [8] = '{8'h4A, 8'h55, 8'h93, 8'hE5, 8'h10, 8'h20, 8'h30, 8'h40};
        logic [7:0] c [8] = '{8'hFF, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        logic [7:0] f [8] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        run_frame("R5 classic", 6'h10, 4'd4, 1'b0, a, 4);
        run_frame("R6 enhanced", 6'h10, 4'd4, 1'b1, a, 4);
        run_frame("R6 enhanced eight", 6'h3A, 4'd15, 1'b1, a, 8);
        header(6'h01, 4'd3, 1'b0);
        send(c, 3);
        check("R7 end-around carry", int'(csum), 8'hFE);
        run_frame("R7 all ones", 6'h22, 4'd8, 1'b1, f, 8);
    endtask

    task automatic t_extra();
        logic [7:0] a [8] = '{8'h11, 8'h22, 8'h77, 8'h88, 8'h00, 8'h00, 8'h00, 8'h00};
        header(6'h07, 4'd2, 1'b0);
        send(a, 4);
        check("R8 extra bytes ignored", int'(csum), int'(m_csum(a, 2, 1'b0, 8'h00)));
        check("R8 last closes", int'(csum_done), 1);
    endtask

    task automatic t_hold_and_rx();
        logic [7:0] a [8] = '{8'h01, 8'h02, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        logic [7:0] exp;
        header(6'h2C, 4'd3, 1'b1);
        check("R9 done low while open", int'(csum_done), 0);
        rx_check(8'h00);
        check("R10 strobe before done ignored", int'(chk_err), 0);
        send(a, 3);
        exp = m_csum(a, 3, 1'b1, m_pid(6'h2C));
        repeat (5) @(negedge clk);
        check("R9 csum held", int'(csum), int'(exp));
        check("R9 done held", int'(csum_done), 1);
        rx_check(exp ^ 8'h01);
        check("R10 mismatch flagged", int'(chk_err), 1);
        rx_check(exp);
        check("R10 match clears", int'(chk_err), 0);
        rx_check(exp ^ 8'h80);
        check("R10 mismatch again", int'(chk_err), 1);
        header(6'h2C, 4'd3, 1'b1);
        check("R10 header clears err", int'(chk_err), 0);
        check("R9 header clears done", int'(csum_done), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pid();
        t_len();
        t_sums();
        t_extra();
        t_hold_and_rx();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule